// File: doc/BRIEF.md
# Bulk IN NAK Interrupt Controller

This block watches the token events that the USB engine reports for seven bulk IN endpoints, numbered 0 to 6. When an IN token reaches an endpoint that has no data armed, the block tells the handshake logic to answer with NAK in that same cycle. It also latches a pending flag for that endpoint, so firmware can learn which endpoints are being polled while empty.

A microcontroller reaches the block through a byte-wide register bus with two registers. The first holds the pending flags, and writing a 1 to a flag clears it. The second holds a per-endpoint enable mask. The pending flags are gated by the mask and by one global NAK-interrupt enable, which is taken from a wider global interrupt-enable input. The result drives a single registered interrupt-request level.

Top module: `bulk_nak_irq`

## Requirements
- R1: Endpoints 0..6 map to bits 0..6 of both registers. Bit 7 of the read data is always 0.
- R2: A cycle with `tok_valid`=1, `tok_ep`=n (n<=6) and `ep_armed[n]`=0 raises `nak_send` combinationally in that cycle and sets pending bit n at the next clock edge.
- R3: Address 0x7FB0 reads the pending flags and address 0x7FB1 reads the enable mask, combinationally on `bus_rdata`. Any other address reads 0x00.
- R4: A write to 0x7FB0 clears every pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R5: A write to 0x7FB1 loads data bits 6..0 into the enable mask. Such a write does not alter the pending flags.
- R6: `irq` is a registered level. One clock after `glob_ien[5]`=1 and (pending AND mask) is non-zero, `irq` is 1. One clock after either condition goes false, `irq` is 0.
- R7: Synchronous active-high `rst` clears the pending flags, the enable mask and `irq`.
- R8: If a NAK event and a write-1 clear hit the same pending bit in the same cycle, the bit ends set.
- R9: A token to an armed endpoint, or to an endpoint number 7..15, raises no `nak_send` and leaves the pending flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | An IN token event is present this cycle |
| tok_ep | input | 4 | Endpoint number of the token |
| ep_armed | input | 7 | Per-endpoint flag: data is armed for transfer |
| nak_send | output | 1 | Tells the handshake logic to answer with NAK |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational from the address |
| glob_ien | input | 8 | Global interrupt enables; bit 5 gates NAK interrupts |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check the following on every cycle:
- every NAK event sets its flag, even against a simultaneous clear;
- a clear write empties the addressed bits unless a NAK event hits them;
- ignored tokens leave the flags untouched;
- the request never rises without an enabled pending source, and falls whenever the global enable is low;
- bit 7 reads zero.

Only the bench scenarios can show the following:
- the exact decode over all sixteen endpoint numbers, with the endpoint both armed and unarmed;
- the readback at both addresses and at other addresses;
- the full enable-mask sweep against several pending patterns;
- the one-cycle latency of the request;
- a reset in the middle of a run.

// File: rtl/nak_irq_pkg.sv
package nak_irq_pkg;

    localparam int EP_COUNT      = 7;
    localparam int EP_IDX_W      = 4;
    localparam int REG_W         = 8;
    localparam int ADDR_W        = 16;
    localparam int GIEN_W        = 8;
    localparam int GLOBAL_EN_BIT = 5;

    localparam logic [ADDR_W-1:0] PEND_ADDR = 16'h7FB0;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 16'h7FB1;

    typedef logic [EP_COUNT-1:0] ep_vec_t;

    typedef struct packed {
        logic                valid;
        logic [EP_IDX_W-1:0] ep;
    } token_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        ep_vec_t  data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] pend_a,
        input logic [ADDR_W-1:0] mask_a
    );
        if (a == pend_a)      return SEL_PEND;
        else if (a == mask_a) return SEL_MASK;
        else                  return SEL_NONE;
    endfunction

    function automatic logic [REG_W-1:0] widen(input ep_vec_t v);
        return {{(REG_W-EP_COUNT){1'b0}}, v};
    endfunction

endpackage

// File: rtl/nak_token_decode.sv
module nak_token_decode
    import nak_irq_pkg::*;
(
    input  token_t  tok,
    input  ep_vec_t armed,
    output ep_vec_t set_vec,
    output logic    nak_send
);
    // One comparator per endpoint; numbers above the last endpoint match none.
    for (genvar i = 0; i < EP_COUNT; i++) begin : g_ep
        assign set_vec[i] = tok.valid
                         && (tok.ep == EP_IDX_W'(i))
                         && !armed[i];
    end

    assign nak_send = |set_vec;
endmodule

// File: rtl/nak_reg_bank.sv
module nak_reg_bank
    import nak_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  reg_sel_e         rd_sel,
    input  ep_vec_t          set_vec,
    output ep_vec_t          pend,
    output ep_vec_t          mask,
    output logic [REG_W-1:0] rdata
);
    ep_vec_t clr_vec;
    ep_vec_t pend_q;
    ep_vec_t mask_q;

    assign clr_vec = (req.wr && req.sel == SEL_PEND) ? req.data : '0;

    // Pending flags: a set event takes precedence over a write-1 clear.
    for (genvar i = 0; i < EP_COUNT; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst)             pend_q[i] <= 1'b0;
            else if (set_vec[i]) pend_q[i] <= 1'b1;
            else if (clr_vec[i]) pend_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                 mask_q <= '0;
        else if (req.wr && req.sel == SEL_MASK) mask_q <= req.data;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_PEND: rdata = widen(pend_q);
            SEL_MASK: rdata = widen(mask_q);
            default:  rdata = '0;
        endcase
    end

    assign pend = pend_q;
    assign mask = mask_q;
endmodule

// File: rtl/nak_irq_gen.sv
module nak_irq_gen
    import nak_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ep_vec_t pend,
    input  ep_vec_t mask,
    input  logic    global_en,
    output logic    irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= global_en && |(pend & mask);
    end

    assign irq = irq_q;
endmodule

// File: rtl/bulk_nak_irq.sv
module bulk_nak_irq
    import nak_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PEND_A = PEND_ADDR,
    parameter logic [ADDR_W-1:0] MASK_A = MASK_ADDR,
    parameter int                GEN_BIT = GLOBAL_EN_BIT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tok_valid,
    input  logic [EP_IDX_W-1:0] tok_ep,
    input  logic [EP_COUNT-1:0] ep_armed,
    output logic                nak_send,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [GIEN_W-1:0]   glob_ien,
    output logic                irq
);
    token_t   tok;
    bus_req_t req;
    reg_sel_e sel;
    ep_vec_t  set_vec;
    ep_vec_t  pend_vec;
    ep_vec_t  mask_vec;
    logic     unused_bits;

    assign tok.valid = tok_valid;
    assign tok.ep    = tok_ep;

    assign sel      = decode_addr(bus_addr, PEND_A, MASK_A);
    assign req.wr   = bus_wr;
    assign req.sel  = sel;
    assign req.data = bus_wdata[EP_COUNT-1:0];

    assign unused_bits = ^{glob_ien, bus_wdata};

    nak_token_decode u_dec (
        .tok      (tok),
        .armed    (ep_armed),
        .set_vec  (set_vec),
        .nak_send (nak_send)
    );

    nak_reg_bank u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_sel  (sel),
        .set_vec (set_vec),
        .pend    (pend_vec),
        .mask    (mask_vec),
        .rdata   (bus_rdata)
    );

    nak_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_vec),
        .mask      (mask_vec),
        .global_en (glob_ien[GEN_BIT]),
        .irq       (irq)
    );
endmodule

// File: rtl/nak_irq_checker.sv
module nak_irq_checker
    import nak_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tok_valid,
    input logic [EP_IDX_W-1:0] tok_ep,
    input logic                nak_send,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input ep_vec_t             wdata_lo,
    input logic [REG_W-1:0]    bus_rdata,
    input logic                gen,
    input ep_vec_t             pend_vec,
    input ep_vec_t             mask_vec,
    input logic                irq
);
    ep_vec_t hit;
    logic    clr_wr;

    assign hit    = ep_vec_t'(1) << tok_ep;
    assign clr_wr = bus_wr && (bus_addr == PEND_ADDR);

    // R1: upper read bit is always zero
    a_r1_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1] == 1'b0);

    // R2: a NAK only accompanies a valid token for an existing endpoint
    a_r2_nak_valid: assert property (@(posedge clk) disable iff (rst)
        nak_send |-> (tok_valid && tok_ep < EP_IDX_W'(EP_COUNT)));

    // R2 and R8: a NAK event always leaves its flag set, clear or not
    a_r8_set_sticks: assert property (@(posedge clk) disable iff (rst)
        nak_send |=> ((pend_vec & $past(hit)) == $past(hit)));

    // R4: a clear write with no NAK event empties the written bits
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !nak_send) |=> ((pend_vec & $past(wdata_lo)) == '0));

    // R9: an ignored token does not move the flags
    a_r9_ignored: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !nak_send && !clr_wr) |=> $stable(pend_vec));

    // R6: global enable low forces the request low next cycle
    a_r6_gate_off: assert property (@(posedge clk) disable iff (rst)
        !gen |=> !irq);

    // R6: request only after an enabled pending source
    a_r6_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(pend_vec & mask_vec)));
endmodule

bind bulk_nak_irq nak_irq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_ep    (tok_ep),
    .nak_send  (nak_send),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wdata_lo  (bus_wdata[nak_irq_pkg::EP_COUNT-1:0]),
    .bus_rdata (bus_rdata),
    .gen       (glob_ien[nak_irq_pkg::GLOBAL_EN_BIT]),
    .pend_vec  (pend_vec),
    .mask_vec  (mask_vec),
    .irq       (irq)
);

// File: tb/bulk_nak_irq_test.sv
`timescale 1ns/1ps
module bulk_nak_irq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        tok_valid;
    logic [3:0]  tok_ep;
    logic [6:0]  ep_armed;
    logic        nak_send;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [7:0]  glob_ien;
    logic        irq;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [6:0] exp_pend;

    localparam logic [15:0] A_PEND = 16'h7FB0;
    localparam logic [15:0] A_MASK = 16'h7FB1;

    always #4 clk = ~clk;

    bulk_nak_irq uut (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .ep_armed(ep_armed), .nak_send(nak_send), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ien(glob_ien), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == A_PEND) exp_pend = exp_pend & ~d[6:0];
    endtask

    task automatic token(input logic [3:0] ep, input logic [6:0] arm, input string req);
        logic exp_nak;
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = ep; ep_armed = arm;
        exp_nak = (ep < 7) && !arm[ep[2:0]];
        #1;
        check(req, nak_send, exp_nak);
        @(negedge clk);
        tok_valid = 1'b0;
        if (exp_nak) exp_pend[ep[2:0]] = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; tok_valid = 0; tok_ep = 0; ep_armed = 0;
        bus_addr = 0; bus_wr = 0; bus_wdata = 0; glob_ien = 0;
        exp_pend = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        rd(A_PEND, d); check("R7 pend reset", d, 8'h00);
        rd(A_MASK, d); check("R7 mask reset", d, 8'h00);
        check("R7 irq reset", irq, 1'b0);

        // R2/R9: every endpoint number, armed and unarmed
        for (int ep = 0; ep < 16; ep++) begin
            for (int arm = 0; arm < 2; arm++) begin
                logic [6:0] av;
                av = arm[0] ? 7'h7F : 7'h00;
                token(ep[3:0], av, (ep < 7 && arm == 0) ? "R2 nak" : "R9 no nak");
                rd(A_PEND, d);
                check((ep < 7 && arm == 0) ? "R2 pend set" : "R9 pend held", d, {1'b0, exp_pend});
                wr(A_PEND, 8'hFF);
                rd(A_PEND, d); check("R4 clear all", d, 8'h00);
            end
        end

        // R9: only the addressed endpoint armed
        token(4'd3, 7'b0001000, "R9 armed ep3");
        token(4'd2, 7'b0001000, "R2 ep2 unarmed");
        rd(A_PEND, d); check("R9 armed leaves bit", d, 8'h04);

        // R4: partial clears
        for (int ep = 0; ep < 7; ep++) token(ep[3:0], 7'h00, "R2 fill");
        wr(A_PEND, 8'h55);
        rd(A_PEND, d); check("R4 partial clear", d, 8'h2A);
        wr(A_PEND, 8'h00);
        rd(A_PEND, d); check("R4 zero write keeps", d, 8'h2A);

        // R3: other addresses read zero, R1 bit 7
        rd(16'h7FB2, d); check("R3 other addr", d, 8'h00);
        rd(16'h0000, d); check("R3 low addr", d, 8'h00);

        // R5: mask sweep, pending untouched
        for (int v = 0; v < 256; v++) begin
            wr(A_MASK, v[7:0]);
            rd(A_MASK, d); check("R5 R1 mask readback", d, {1'b0, v[6:0]});
        end
        rd(A_PEND, d); check("R5 pend untouched", d, 8'h2A);

        // R8: set and clear same bit in same cycle
        wr(A_PEND, 8'hFF);
        @(negedge clk);
        tok_valid = 1; tok_ep = 4'd3; ep_armed = 0;
        bus_addr = A_PEND; bus_wdata = 8'h0F; bus_wr = 1;
        @(negedge clk);
        tok_valid = 0; bus_wr = 0;
        rd(A_PEND, d); check("R8 set wins", d, 8'h08);
        exp_pend = 7'h08;

        // R6: request versus pending pattern, mask and global enable
        begin
            logic [6:0] pats [5];
            pats = '{7'h00, 7'h01, 7'h40, 7'h2A, 7'h7F};
            for (int p = 0; p < 5; p++) begin
                wr(A_PEND, 8'hFF);
                for (int ep = 0; ep < 7; ep++)
                    if (pats[p][ep]) token(ep[3:0], 7'h00, "R2 pattern");
                for (int g = 0; g < 2; g++) begin
                    for (int m = 0; m < 128; m++) begin
                        glob_ien = g[0] ? 8'h20 : 8'hDF;
                        wr(A_MASK, {1'b0, m[6:0]});
                        @(negedge clk);
                        check("R6 irq", irq, g[0] && ((pats[p] & m[6:0]) != 0));
                    end
                end
            end
        end

        // R6: latency of rise and fall
        wr(A_PEND, 8'hFF);
        wr(A_MASK, 8'h7F);
        glob_ien = 8'h20;
        @(negedge clk);
        tok_valid = 1; tok_ep = 4'd6; ep_armed = 0;
        @(negedge clk);
        tok_valid = 0;
        check("R6 irq not yet", irq, 1'b0);
        @(negedge clk);
        check("R6 irq rises", irq, 1'b1);
        wr(A_PEND, 8'h40);
        check("R6 irq lags clear", irq, 1'b1);
        @(negedge clk);
        check("R6 irq falls", irq, 1'b0);

        // R7: mid-run reset
        token(4'd1, 7'h00, "R2 pre reset");
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd(A_PEND, d); check("R7 pend after reset", d, 8'h00);
        rd(A_MASK, d); check("R7 mask after reset", d, 8'h00);
        check("R7 irq after reset", irq, 1'b0);

        finish_run();
    end
endmodule